// File: doc/BRIEF.md
# Register Poll With Retry Unit

This unit carries out one wait-on-register command at a time. A packet front end hands it a decoded command: a compare function, an operation select, a poll address, a request address, a reference value, a mask and a packed retry/interval dword. The unit reads the poll location through a simple read port and masks the returned value. It compares the result with the reference under the selected function. On a pass it raises `done`. On a fail it either waits a programmable number of cycles and reads again, or raises `timeout` once the retries are used up.

In request-then-poll mode the unit first writes the reference value to the request address through a one-cycle write strobe, and only then starts polling. New commands are taken only while the unit is idle.

Top module: `regPollUnit`

## Requirements
- R1: After reset the unit is idle: `cmdReady` is 1 and `done`, `timeout`, `rdReq` and `wrEn` are 0.
- R2: A command is taken only when `cmdValid` and `cmdReady` are both high. A `cmdValid` pulse while the unit is busy is ignored. It changes neither the running command's number of reads nor its outcome, and it starts no further reads afterwards.
- R3: Function code 3 (equal) passes when (read data AND mask) equals the reference. The unit raises `done` in the cycle after the passing response.
- R4: Function code 0 (always) passes on the first response whatever the data, so exactly one read is made.
- R5: The remaining codes compare the masked read value with the reference as unsigned numbers: 1 less than, 2 less or equal, 4 not equal, 5 greater or equal, 6 greater than. Code 7 never passes.
- R6: The retry count sits in bits 27:16 of the retry/interval dword, and the poll interval sits in bits 15:0. Bits 31:28 are ignored. A command that never passes makes retry+1 reads and then raises `timeout` in the cycle after the last response. A retry count of 0 therefore gives a single read.
- R7: After a failed response with retries left, the next `rdReq` comes exactly interval+1 cycles after the response cycle. An interval of 0 gives a back-to-back reissue.
- R8: With operation select 1, the unit drives `wrEn` for exactly one cycle before the first read. In that cycle `wrAddr` is the request address and `wrData` is the reference. With operation select 0 there is no write.
- R9: `done` and `timeout` are each high for exactly one cycle, never together, and `cmdReady` is high in that cycle.
- R10: Every read attempt is a single-cycle `rdReq` with `rdAddr` equal to the poll address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Unit idle, command will be taken |
| cmdFunc | input | 3 | Compare function code |
| cmdOpSel | input | 1 | 0 poll only, 1 write request then poll |
| cmdPollAddr | input | ADDR_W | Address that is polled |
| cmdReqAddr | input | ADDR_W | Address written in request mode |
| cmdRef | input | DATA_W | Reference value (also the request value) |
| cmdMask | input | DATA_W | Mask applied to read data |
| cmdRetryIntv | input | DATA_W | Retry count [27:16], poll interval [15:0] |
| rdReq | output | 1 | One-cycle read request |
| rdAddr | output | ADDR_W | Read address |
| rdValid | input | 1 | Read response valid |
| rdData | input | DATA_W | Read response data |
| wrEn | output | 1 | One-cycle write strobe |
| wrAddr | output | ADDR_W | Write address |
| wrData | output | DATA_W | Write data |
| done | output | 1 | Condition met, one-cycle pulse |
| timeout | output | 1 | Retries exhausted, one-cycle pulse |

## Verification
The assertions assume that the read port answers each `rdReq` with exactly one `rdValid` pulse, at least one cycle later, and never raises `rdValid` without a pending request. The bench memory model returns every response a fixed one cycle after the request cycle and only for requests it has seen. Command fields are assumed stable only in the accept cycle. The bench changes them freely at other times, including a command pulse driven into a busy unit.

// File: rtl/pollPkg.sv
package pollPkg;

  typedef enum logic [2:0] {
    FN_ALWAYS = 3'd0,
    FN_LT     = 3'd1,
    FN_LE     = 3'd2,
    FN_EQ     = 3'd3,
    FN_NE     = 3'd4,
    FN_GE     = 3'd5,
    FN_GT     = 3'd6,
    FN_NEVER  = 3'd7
  } pollFuncE;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_ISSUE,
    ST_RESP,
    ST_WAIT
  } pollStateE;

  typedef struct packed {
    logic loadCmd;
    logic decRetry;
    logic loadWait;
    logic decWait;
  } pollStrobeT;

endpackage

// File: rtl/pollPath.sv
module pollPath
  import pollPkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int RETRY_LSB = 16,
  parameter int RETRY_W   = 12,
  parameter int INTV_W    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  pollStrobeT        stb,
  input  logic [2:0]        cmdFunc,
  input  logic [ADDR_W-1:0] cmdPollAddr,
  input  logic [ADDR_W-1:0] cmdReqAddr,
  input  logic [DATA_W-1:0] cmdRef,
  input  logic [DATA_W-1:0] cmdMask,
  input  logic [DATA_W-1:0] cmdRetryIntv,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] pollAddr,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [DATA_W-1:0] refVal,
  output logic              pass,
  output logic              retryZero,
  output logic              intvZero,
  output logic              waitOne
);

  pollFuncE            funcQ;
  logic [DATA_W-1:0]   maskQ;
  logic [RETRY_W-1:0]  retryQ;
  logic [INTV_W-1:0]   intvQ;
  logic [INTV_W-1:0]   waitQ;
  logic [DATA_W-1:0]   masked;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      funcQ    <= FN_ALWAYS;
      pollAddr <= '0;
      reqAddr  <= '0;
      refVal   <= '0;
      maskQ    <= '0;
      retryQ   <= '0;
      intvQ    <= '0;
      waitQ    <= '0;
    end else begin
      if (stb.loadCmd) begin
        funcQ    <= pollFuncE'(cmdFunc);
        pollAddr <= cmdPollAddr;
        reqAddr  <= cmdReqAddr;
        refVal   <= cmdRef;
        maskQ    <= cmdMask;
        retryQ   <= cmdRetryIntv[RETRY_LSB +: RETRY_W];
        intvQ    <= cmdRetryIntv[INTV_W-1:0];
      end else if (stb.decRetry) begin
        retryQ <= retryQ - 1'b1;
      end
      if (stb.loadWait) begin
        waitQ <= intvQ;
      end else if (stb.decWait) begin
        waitQ <= waitQ - 1'b1;
      end
    end
  end

  assign masked = rdData & maskQ;

  always_comb begin
    unique case (funcQ)
      FN_ALWAYS: pass = 1'b1;
      FN_LT:     pass = masked <  refVal;
      FN_LE:     pass = masked <= refVal;
      FN_EQ:     pass = masked == refVal;
      FN_NE:     pass = masked != refVal;
      FN_GE:     pass = masked >= refVal;
      FN_GT:     pass = masked >  refVal;
      default:   pass = 1'b0;
    endcase
  end

  assign retryZero = (retryQ == '0);
  assign intvZero  = (intvQ == '0);
  assign waitOne   = (waitQ <= 1);

  // R6
  retry_no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.decRetry |-> (retryQ != '0));

  // R7
  wait_no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.decWait |-> (waitQ > 1));

  // R7
  wait_load_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadWait |-> (intvQ != '0));

endmodule

// File: rtl/pollCtrl.sv
module pollCtrl
  import pollPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic       cmdOpSel,
  input  logic       rdValid,
  input  logic       pass,
  input  logic       retryZero,
  input  logic       intvZero,
  input  logic       waitOne,
  output logic       cmdReady,
  output logic       rdReq,
  output logic       wrEn,
  output logic       done,
  output logic       timeout,
  output pollStrobeT stb
);

  pollStateE state, nextState;
  logic      doneD, toD;

  always_comb begin
    stb       = '0;
    nextState = state;
    doneD     = 1'b0;
    toD       = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (cmdValid) begin
          stb.loadCmd = 1'b1;
          nextState   = cmdOpSel ? ST_WRITE : ST_ISSUE;
        end
      end
      ST_WRITE: nextState = ST_ISSUE;
      ST_ISSUE: nextState = ST_RESP;
      ST_RESP: begin
        if (rdValid) begin
          if (pass) begin
            doneD     = 1'b1;
            nextState = ST_IDLE;
          end else if (retryZero) begin
            toD       = 1'b1;
            nextState = ST_IDLE;
          end else begin
            stb.decRetry = 1'b1;
            if (intvZero) begin
              nextState = ST_ISSUE;
            end else begin
              stb.loadWait = 1'b1;
              nextState    = ST_WAIT;
            end
          end
        end
      end
      ST_WAIT: begin
        if (waitOne) nextState = ST_ISSUE;
        else         stb.decWait = 1'b1;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      done    <= 1'b0;
      timeout <= 1'b0;
    end else begin
      state   <= nextState;
      done    <= doneD;
      timeout <= toD;
    end
  end

  assign cmdReady = (state == ST_IDLE);
  assign rdReq    = (state == ST_ISSUE);
  assign wrEn     = (state == ST_WRITE);

  // R9
  done_timeout_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(done && timeout));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9
  timeout_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    timeout |=> !timeout);

  // R9
  result_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done || timeout) |-> cmdReady);

  // R8
  write_then_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> rdReq);

  // R10
  read_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> !rdReq);

  // R2
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq || wrEn) |-> !cmdReady);

endmodule

// File: rtl/regPollUnit.sv
module regPollUnit
  import pollPkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int RETRY_LSB = 16,
  parameter int RETRY_W   = 12,
  parameter int INTV_W    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [2:0]        cmdFunc,
  input  logic              cmdOpSel,
  input  logic [ADDR_W-1:0] cmdPollAddr,
  input  logic [ADDR_W-1:0] cmdReqAddr,
  input  logic [DATA_W-1:0] cmdRef,
  input  logic [DATA_W-1:0] cmdMask,
  input  logic [DATA_W-1:0] cmdRetryIntv,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic              rdValid,
  input  logic [DATA_W-1:0] rdData,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              done,
  output logic              timeout
);

  localparam int RETRY_MSB = RETRY_LSB + RETRY_W - 1;

  initial begin
    if (RETRY_MSB >= DATA_W || INTV_W > RETRY_LSB)
      $error("regPollUnit: retry/interval fields do not fit the dword");
  end

  pollStrobeT stb;
  logic       pass, retryZero, intvZero, waitOne;

  pollCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .cmdOpSel  (cmdOpSel),
    .rdValid   (rdValid),
    .pass      (pass),
    .retryZero (retryZero),
    .intvZero  (intvZero),
    .waitOne   (waitOne),
    .cmdReady  (cmdReady),
    .rdReq     (rdReq),
    .wrEn      (wrEn),
    .done      (done),
    .timeout   (timeout),
    .stb       (stb)
  );

  pollPath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .RETRY_LSB (RETRY_LSB),
    .RETRY_W   (RETRY_W),
    .INTV_W    (INTV_W)
  ) u_path (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .cmdFunc      (cmdFunc),
    .cmdPollAddr  (cmdPollAddr),
    .cmdReqAddr   (cmdReqAddr),
    .cmdRef       (cmdRef),
    .cmdMask      (cmdMask),
    .cmdRetryIntv (cmdRetryIntv),
    .rdData       (rdData),
    .pollAddr     (rdAddr),
    .reqAddr      (wrAddr),
    .refVal       (wrData),
    .pass         (pass),
    .retryZero    (retryZero),
    .intvZero     (intvZero),
    .waitOne      (waitOne)
  );

endmodule

// File: tb/regPollUnit_bench.sv
`timescale 1ns/1ps
module regPollUnit_bench;

  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cmdValid = 1'b0;
  logic          cmdReady;
  logic [2:0]    cmdFunc = '0;
  logic          cmdOpSel = 1'b0;
  logic [AW-1:0] cmdPollAddr = '0;
  logic [AW-1:0] cmdReqAddr = '0;
  logic [DW-1:0] cmdRef = '0;
  logic [DW-1:0] cmdMask = '0;
  logic [DW-1:0] cmdRetryIntv = '0;
  logic          rdReq;
  logic [AW-1:0] rdAddr;
  logic          rdValid = 1'b0;
  logic [DW-1:0] rdData = '0;
  logic          wrEn;
  logic [AW-1:0] wrAddr;
  logic [DW-1:0] wrData;
  logic          done;
  logic          timeout;

  always #2.5 clk = ~clk;

  regPollUnit u_regPollUnit (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdFunc(cmdFunc), .cmdOpSel(cmdOpSel), .cmdPollAddr(cmdPollAddr),
    .cmdReqAddr(cmdReqAddr), .cmdRef(cmdRef), .cmdMask(cmdMask),
    .cmdRetryIntv(cmdRetryIntv), .rdReq(rdReq), .rdAddr(rdAddr),
    .rdValid(rdValid), .rdData(rdData), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .done(done), .timeout(timeout)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // observation and memory model state
  logic [DW-1:0] memVals [16];
  int            rdCycle [64];
  int            vCycle  [64];
  int            rdCount, vCount, wrCount, wrCycle, doneCount, toCount, endCycle;
  logic [AW-1:0] expPollAddr, wrAddrSeen;
  logic [DW-1:0] wrDataSeen;
  bit            badAddr, widthBad, readyBad, bothBad, prevDone, prevTo;
  int            pend;

  task automatic clearObs();
    rdCount = 0; vCount = 0; wrCount = 0; wrCycle = 0;
    doneCount = 0; toCount = 0; endCycle = 0;
    badAddr = 0; widthBad = 0; readyBad = 0; bothBad = 0;
    wrAddrSeen = '0; wrDataSeen = '0;
  endtask

  always @(negedge clk) begin
    // response path: one cycle after the request cycle
    rdValid = 1'b0;
    if (pend > 0) begin
      pend = pend - 1;
      if (pend == 0) begin
        rdValid = 1'b1;
        rdData  = memVals[(vCount < 16) ? vCount : 15];
        if (vCount < 64) vCycle[vCount] = cyc;
        vCount = vCount + 1;
      end
    end
    if (rdReq) begin
      if (rdCount < 64) rdCycle[rdCount] = cyc;
      rdCount = rdCount + 1;
      if (rdAddr !== expPollAddr) badAddr = 1;
      pend = 1;
    end
    if (wrEn) begin
      wrCount = wrCount + 1; wrCycle = cyc;
      wrAddrSeen = wrAddr; wrDataSeen = wrData;
    end
    if (done)    begin doneCount = doneCount + 1; endCycle = cyc; end
    if (timeout) begin toCount   = toCount + 1;   endCycle = cyc; end
    if ((done && prevDone) || (timeout && prevTo)) widthBad = 1;
    if ((done || timeout) && !cmdReady) readyBad = 1;
    if (done && timeout) bothBad = 1;
    prevDone = done; prevTo = timeout;
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit expPass(input int fn, input logic [31:0] v, input logic [31:0] r);
    case (fn)
      0: return 1'b1;
      1: return v < r;
      2: return v <= r;
      3: return v == r;
      4: return v != r;
      5: return v >= r;
      6: return v > r;
      default: return 1'b0;
    endcase
  endfunction

  task automatic setMem(input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] c);
    for (int i = 0; i < 16; i++) memVals[i] = c;
    memVals[0] = a; memVals[1] = b;
  endtask

  task automatic runCmd(input int fn, input bit op, input logic [AW-1:0] pa,
                        input logic [AW-1:0] ra, input logic [DW-1:0] rf,
                        input logic [DW-1:0] mk, input logic [DW-1:0] ri);
    @(negedge clk);
    clearObs();
    expPollAddr = pa;
    cmdFunc = fn[2:0]; cmdOpSel = op; cmdPollAddr = pa; cmdReqAddr = ra;
    cmdRef = rf; cmdMask = mk; cmdRetryIntv = ri; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    for (int k = 0; k < 20000; k++) begin
      if (doneCount + toCount > 0) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic tReset();
    chk("R1", "cmdReady", cmdReady, 1);
    chk("R1", "done", done, 0);
    chk("R1", "timeout", timeout, 0);
    chk("R1", "rdReq", rdReq, 0);
    chk("R1", "wrEn", wrEn, 0);
  endtask

  task automatic tEqualMatch();
    setMem(32'h0000_0100, 32'h0000_AB12, 32'h0000_77FF);
    runCmd(3, 0, 16'h1230, 16'h4560, 32'hFF, 32'hFF, (32'd5 << 16) | 32'd3);
    chk("R3", "reads", rdCount, 3);
    chk("R3", "done count", doneCount, 1);
    chk("R3", "timeout count", toCount, 0);
    chk("R3", "done latency", endCycle - vCycle[2], 1);
    chk("R7", "gap interval 3", rdCycle[2] - vCycle[1], 4);
    chk("R10", "read address", badAddr, 0);
    chk("R8", "no write in mode 0", wrCount, 0);
    chk("R9", "pulse width", widthBad, 0);
    chk("R9", "ready at result", readyBad, 0);
  endtask

  task automatic tAlways();
    setMem(32'h0, 32'h0, 32'h0);
    runCmd(0, 0, 16'h0040, 16'h0, 32'h55, 32'hFFFF_FFFF, (32'd7 << 16) | 32'd2);
    chk("R4", "reads", rdCount, 1);
    chk("R4", "done count", doneCount, 1);
    chk("R4", "timeout count", toCount, 0);
  endtask

  task automatic tTimeout();
    setMem(32'h1, 32'h1, 32'h1);
    runCmd(3, 0, 16'h0088, 16'h0, 32'h2, 32'hFFFF_FFFF, 32'hF004_0002);
    chk("R6", "reads retry 4", rdCount, 5);
    chk("R6", "timeout count", toCount, 1);
    chk("R6", "done count", doneCount, 0);
    chk("R6", "timeout latency", endCycle - vCycle[4], 1);
    chk("R7", "gap interval 2", rdCycle[1] - vCycle[0], 3);
    chk("R9", "exclusive", bothBad, 0);
    runCmd(3, 0, 16'h0088, 16'h0, 32'h2, 32'hFFFF_FFFF, 32'h0000_0009);
    chk("R6", "reads retry 0", rdCount, 1);
    chk("R6", "timeout retry 0", toCount, 1);
    runCmd(3, 0, 16'h0088, 16'h0, 32'h2, 32'hFFFF_FFFF, 32'h0002_0000);
    chk("R6", "reads retry 2", rdCount, 3);
    chk("R7", "gap interval 0", rdCycle[2] - vCycle[1], 1);
    chk("R9", "pulse width", widthBad, 0);
  endtask

  task automatic tFuncs();
    logic [31:0] refs [3];
    refs[0] = 32'h34; refs[1] = 32'h35; refs[2] = 32'h33;
    setMem(32'h0000_1234, 32'h0000_1234, 32'h0000_1234);
    for (int fn = 0; fn < 8; fn++) begin
      for (int r = 0; r < 3; r++) begin
        bit ep;
        ep = expPass(fn, 32'h34, refs[r]);
        runCmd(fn, 0, 16'h0010, 16'h0, refs[r], 32'hFF, 32'h0);
        chk("R5", $sformatf("func %0d ref %0h done", fn, refs[r]), doneCount, ep);
        chk("R5", $sformatf("func %0d ref %0h timeout", fn, refs[r]), toCount, !ep);
      end
    end
    setMem(32'h8000_0000, 32'h8000_0000, 32'h8000_0000);
    runCmd(6, 0, 16'h0010, 16'h0, 32'h1, 32'hFFFF_FFFF, 32'h0);
    chk("R5", "unsigned greater", doneCount, 1);
  endtask

  task automatic tMode1();
    setMem(32'h0000_00A5, 32'h0, 32'h0);
    runCmd(3, 1, 16'h0200, 16'h0300, 32'hA5, 32'hFF, (32'd3 << 16) | 32'd1);
    chk("R8", "write count", wrCount, 1);
    chk("R8", "write address", wrAddrSeen, 32'h0300);
    chk("R8", "write data", wrDataSeen, 32'hA5);
    chk("R8", "write before read", rdCycle[0] - wrCycle, 1);
    chk("R8", "done", doneCount, 1);
    chk("R10", "read address", badAddr, 0);
  endtask

  task automatic tBusy();
    int readsAtEnd;
    setMem(32'h1, 32'h1, 32'h1);
    @(negedge clk);
    clearObs();
    expPollAddr = 16'h0500;
    cmdFunc = 3'd3; cmdOpSel = 1'b0; cmdPollAddr = 16'h0500; cmdReqAddr = '0;
    cmdRef = 32'h2; cmdMask = 32'hFFFF_FFFF; cmdRetryIntv = (32'd2 << 16) | 32'd20;
    cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    repeat (6) @(negedge clk);
    chk("R2", "not ready while busy", cmdReady, 0);
    cmdFunc = 3'd0; cmdOpSel = 1'b1; cmdPollAddr = 16'h0999; cmdRetryIntv = 32'h0;
    cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    for (int k = 0; k < 2000; k++) begin
      if (doneCount + toCount > 0) break;
      @(negedge clk);
    end
    repeat (10) @(negedge clk);
    readsAtEnd = rdCount;
    chk("R2", "reads of running command", readsAtEnd, 3);
    chk("R2", "outcome timeout", toCount, 1);
    chk("R2", "no done", doneCount, 0);
    chk("R2", "no write from ignored command", wrCount, 0);
    chk("R2", "address unchanged", badAddr, 0);
    chk("R2", "idle afterwards", cmdReady, 1);
  endtask

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    pend = 0; prevDone = 0; prevTo = 0;
    clearObs();
    expPollAddr = '0;
    repeat (4) @(negedge clk);
    tReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    tReset();
    tEqualMatch();
    tAlways();
    tTimeout();
    tFuncs();
    tMode1();
    tBusy();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule